// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block sits between the analog comparators of a hysteretic synchronous buck stage and its two gate drivers. From the regulation comparator's decision it derives a high-side and a low-side gate command and guarantees that the two never overlap, with a programmable break-before-make gap counted in cycles of a fast clock.

On top of that basic switching it applies cycle-by-cycle current limiting with hysteresis (the high side is blanked between an upper-threshold trip and a lower-threshold release), a light-load power-save latch that keeps the low side off once inductor current reaches zero, and a three-bit fault bus that can force both switches off or hold the low side on. Every asynchronous input is brought into the clock domain through a two-flop synchronizer; an enable input shuts everything down and clears all held state.

Top module: `buck_gate_ctrl`

## Requirements
- R1: `hs_gate` and `ls_gate` are never high in the same cycle.
- R2: Before either gate turns on, both gates are low for at least `DEAD_CYC` cycles, including the first turn-on after reset or enable; when the opposite gate is already requested at the moment one gate turns off, the gap is exactly `DEAD_CYC` cycles.
- R3: With no fault, no current limit and no power-save hold, `cmp_hi` = 1 drives `hs_gate` high and `cmp_hi` = 0 drives `ls_gate` high, after the two synchronizer stages.
- R4: `ilim_over` = 1 forces `hs_gate` low and lets `ls_gate` conduct; the high side stays blanked while both `ilim_over` and `ilim_under` are 0, and resumes only once `ilim_under` = 1 with `ilim_over` = 0.
- R5: `zc_det` seen while `ls_gate` is high turns `ls_gate` off and holds it off after `zc_det` returns low; `zc_det` seen while `ls_gate` is low has no effect.
- R6: The power-save hold is cleared when the high-side request rises, so the next low-side phase drives `ls_gate` normally.
- R7: `fault[0]` (undervoltage) holds both gates low while asserted and is not remembered once it clears.
- R8: `fault[1]` (overvoltage) is remembered until enable drops; it forces `hs_gate` low and `ls_gate` high (after the dead time) regardless of `cmp_hi` and of the power-save hold.
- R9: `fault[2]` (overtemperature) is remembered until enable drops and holds both gates low; it takes priority over overvoltage, and undervoltage takes priority over both.
- R10: In reset, and within four cycles of `en` going low, both gates are low; dropping `en` clears every held condition, so operation after re-enable starts clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that counts the dead time |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable, asynchronous, active high |
| cmp_hi | input | 1 | Regulation comparator decision: 1 asks for the high side |
| ilim_over | input | 1 | Current sense above the upper limit threshold |
| ilim_under | input | 1 | Current sense below the lower limit threshold |
| zc_det | input | 1 | Inductor current has reached zero |
| fault | input | 3 | Fault overrides: bit 0 undervoltage, bit 1 overvoltage, bit 2 overtemperature |
| hs_gate | output | 1 | High-side gate command, registered |
| ls_gate | output | 1 | Low-side gate command, registered |

## Verification
The hardest state to reach from the ports is a held condition that outlives its cause: the power-save hold, which needs a zero-current pulse landing while the low side actually conducts, and the remembered overvoltage or overtemperature faults. The stimulus first settles the low side on, pulses `zc_det` for one cycle, then observes that the low side stays off until the comparator asks for the high side; faults are swept over all eight bus values for both comparator states, each followed by release to tell held from transient conditions, with `en` cycled in between to prove clearing. Dead-time exactness is measured by a port monitor over a sweep of comparator toggle periods.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

  // Fault override bus, bit 0 is undervoltage.
  typedef struct packed {
    logic ot;   // bit 2: overtemperature
    logic ov;   // bit 1: overvoltage
    logic uv;   // bit 0: undervoltage
  } fault_t;

  localparam int FLT_W = $bits(fault_t);

  // Order of signals in the synchronized input bus.
  localparam int SI_EN    = 0;
  localparam int SI_CMP   = 1;
  localparam int SI_IOVER = 2;
  localparam int SI_IUND  = 3;
  localparam int SI_ZC    = 4;
  localparam int SI_FLT   = 5;
  localparam int SI_W     = SI_FLT + FLT_W;

endpackage

// File: rtl/gdrv_sync.sv
module gdrv_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gdrv_guard.sv
module gdrv_guard
  import gdrv_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   en_s,
  input  logic   cmp_s,
  input  logic   iover_s,
  input  logic   iund_s,
  input  logic   zc_s,
  input  fault_t flt_s,
  input  logic   ls_on,
  output logic   hs_req,
  output logic   ls_req
);

  logic blank_q;    // current-limit blanking of the high side
  logic psave_q;    // low side held off after zero current
  logic ov_q;       // remembered overvoltage
  logic ot_q;       // remembered overtemperature
  logic hs_req_d;
  logic run_ok;
  logic hs_rise;

  assign run_ok = en_s && !flt_s.uv && !ot_q;
  assign hs_req = run_ok && !ov_q && cmp_s && !blank_q;
  assign ls_req = run_ok && (ov_q || ((!cmp_s || blank_q) && !psave_q));
  assign hs_rise = hs_req && !hs_req_d;

  always_ff @(posedge clk) begin
    if (rst || !en_s) begin
      blank_q  <= 1'b0;
      psave_q  <= 1'b0;
      ov_q     <= 1'b0;
      ot_q     <= 1'b0;
      hs_req_d <= 1'b0;
    end else begin
      hs_req_d <= hs_req;

      if (iover_s)     blank_q <= 1'b1;
      else if (iund_s) blank_q <= 1'b0;

      if (hs_rise)              psave_q <= 1'b0;
      else if (zc_s && ls_on)   psave_q <= 1'b1;

      if (flt_s.ov) ov_q <= 1'b1;
      if (flt_s.ot) ot_q <= 1'b1;
    end
  end

endmodule

// File: rtl/gdrv_deadtime.sv
module gdrv_deadtime #(
  parameter int DEAD_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en_s,
  input  logic hs_req,
  input  logic ls_req,
  output logic hs_q,
  output logic ls_q
);

  localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC);
  localparam logic [CW-1:0] RELOAD = CW'(DEAD_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en_s) begin
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
      cnt_q <= RELOAD;
    end else if (hs_q) begin
      if (!hs_req) begin
        hs_q  <= 1'b0;
        cnt_q <= RELOAD;
      end
    end else if (ls_q) begin
      if (!ls_req) begin
        ls_q  <= 1'b0;
        cnt_q <= RELOAD;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (hs_req) begin
      hs_q <= 1'b1;
    end else if (ls_req) begin
      ls_q <= 1'b1;
    end
  end

endmodule

// File: rtl/buck_gate_ctrl.sv
module buck_gate_ctrl
  import gdrv_pkg::*;
#(
  parameter int DEAD_CYC    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cmp_hi,
  input  logic             ilim_over,
  input  logic             ilim_under,
  input  logic             zc_det,
  input  logic [FLT_W-1:0] fault,
  output logic             hs_gate,
  output logic             ls_gate
);

  logic [SI_W-1:0] raw_bus;
  logic [SI_W-1:0] syn_bus;
  logic            hs_req;
  logic            ls_req;
  logic            en_s;

  assign raw_bus[SI_EN]                 = en;
  assign raw_bus[SI_CMP]                = cmp_hi;
  assign raw_bus[SI_IOVER]              = ilim_over;
  assign raw_bus[SI_IUND]               = ilim_under;
  assign raw_bus[SI_ZC]                 = zc_det;
  assign raw_bus[SI_FLT +: FLT_W]       = fault;

  gdrv_sync #(.W(SI_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_bus),
    .q   (syn_bus)
  );

  assign en_s = syn_bus[SI_EN];

  gdrv_guard u_guard (
    .clk     (clk),
    .rst     (rst),
    .en_s    (en_s),
    .cmp_s   (syn_bus[SI_CMP]),
    .iover_s (syn_bus[SI_IOVER]),
    .iund_s  (syn_bus[SI_IUND]),
    .zc_s    (syn_bus[SI_ZC]),
    .flt_s   (fault_t'(syn_bus[SI_FLT +: FLT_W])),
    .ls_on   (ls_gate),
    .hs_req  (hs_req),
    .ls_req  (ls_req)
  );

  gdrv_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dt (
    .clk    (clk),
    .rst    (rst),
    .en_s   (en_s),
    .hs_req (hs_req),
    .ls_req (ls_req),
    .hs_q   (hs_gate),
    .ls_q   (ls_gate)
  );

endmodule

// File: rtl/buck_gate_ctrl_chk.sv
module buck_gate_ctrl_chk #(
  parameter int DEAD_CYC = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       ilim_over,
  input logic [2:0] fault,
  input logic       hs_gate,
  input logic       ls_gate
);

  localparam int OW = $clog2(DEAD_CYC + 1) + 1;

  logic [OW-1:0] off_run;

  always_ff @(posedge clk) begin
    if (rst || hs_gate || ls_gate) off_run <= '0;
    else if (off_run < OW'(DEAD_CYC)) off_run <= off_run + 1'b1;
  end

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(hs_gate && ls_gate));

  // R2
  dead_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(hs_gate) || $rose(ls_gate)) |-> (off_run >= OW'(DEAD_CYC)));

  // R4
  ilim_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (ilim_over && $past(ilim_over) && $past(ilim_over, 2) && $past(ilim_over, 3))
      |=> !hs_gate);

  // R7
  uv_off_chk: assert property (@(posedge clk) disable iff (rst)
    (fault[0] && $past(fault[0]) && $past(fault[0], 2) && $past(fault[0], 3))
      |=> (!hs_gate && !ls_gate));

  // R8
  ov_hs_off_chk: assert property (@(posedge clk) disable iff (rst)
    (fault[1] && $past(fault[1]) && $past(fault[1], 2) && $past(fault[1], 3))
      |=> !hs_gate);

  // R9
  ot_off_chk: assert property (@(posedge clk) disable iff (rst)
    (fault[2] && $past(fault[2]) && $past(fault[2], 2) && $past(fault[2], 3))
      |=> (!hs_gate && !ls_gate));

  // R10
  en_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && $past(!en) && $past(!en, 2)) |=> (!hs_gate && !ls_gate));

endmodule

bind buck_gate_ctrl buck_gate_ctrl_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .ilim_over (ilim_over),
  .fault     (fault),
  .hs_gate   (hs_gate),
  .ls_gate   (ls_gate)
);

// File: tb/sim_buck_gate_ctrl.sv
`timescale 1ns/1ps
module sim_buck_gate_ctrl;

  localparam int DT = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       cmp_hi = 1'b0;
  logic       ilim_over = 1'b0;
  logic       ilim_under = 1'b1;
  logic       zc_det = 1'b0;
  logic [2:0] fault = 3'b000;
  logic       hs_gate;
  logic       ls_gate;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int run = 0;
  int gmin = 9999;
  int gmax = 0;
  int overlap = 0;

  always #5 clk = ~clk;

  buck_gate_ctrl #(.DEAD_CYC(DT)) u0 (
    .clk(clk), .rst(rst), .en(en), .cmp_hi(cmp_hi),
    .ilim_over(ilim_over), .ilim_under(ilim_under), .zc_det(zc_det),
    .fault(fault), .hs_gate(hs_gate), .ls_gate(ls_gate)
  );

  // Port monitor: overlap count and length of both-off gaps before each turn-on.
  always @(negedge clk) begin
    if (hs_gate && ls_gate) overlap++;
    if (!hs_gate && !ls_gate) run++;
    else if (run != 0) begin
      if (run < gmin) gmin = run;
      if (run > gmax) gmax = run;
      run = 0;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {hs,ls} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reenable();
    en = 1'b0;
    cyc(6);
    en = 1'b1;
    cyc(14);
  endtask

  function automatic logic [1:0] fault_exp(input logic [2:0] f, input logic c);
    if (f[0]) return 2'b00;
    if (f[2]) return 2'b00;
    if (f[1]) return 2'b01;
    return c ? 2'b10 : 2'b01;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(4);
    // R10 reset state
    check("R10 reset", {hs_gate, ls_gate}, 2'b00);
    rst = 1'b0;
    en = 1'b1;
    cyc(14);
    // R3 main function
    check("R3 cmp low", {hs_gate, ls_gate}, 2'b01);
    cmp_hi = 1'b1; cyc(12);
    check("R3 cmp high", {hs_gate, ls_gate}, 2'b10);
    cmp_hi = 1'b0; cyc(12);
    check("R3 cmp low again", {hs_gate, ls_gate}, 2'b01);

    // R1 R2 dead-time sweep over toggle periods
    for (int hp = 6; hp <= 20; hp++) begin
      gmin = 9999; gmax = 0; overlap = 0;
      for (int t = 0; t < 6; t++) begin
        cmp_hi = ~cmp_hi;
        cyc(hp);
      end
      check_int("R2 gap min", gmin, DT);
      check_int("R2 gap max", gmax, DT);
      check_int("R1 overlap", overlap, 0);
    end
    cmp_hi = 1'b0; cyc(12);

    // R4 current limit with hysteresis
    cmp_hi = 1'b1; cyc(12);
    check("R4 before trip", {hs_gate, ls_gate}, 2'b10);
    ilim_over = 1'b1; ilim_under = 1'b0; cyc(12);
    check("R4 tripped", {hs_gate, ls_gate}, 2'b01);
    ilim_over = 1'b0; cyc(12);
    check("R4 between thresholds", {hs_gate, ls_gate}, 2'b01);
    ilim_under = 1'b1; cyc(12);
    check("R4 released", {hs_gate, ls_gate}, 2'b10);

    // R5 zero-current hold
    cmp_hi = 1'b0; cyc(12);
    check("R5 ls on", {hs_gate, ls_gate}, 2'b01);
    zc_det = 1'b1; cyc(1); zc_det = 1'b0; cyc(12);
    check("R5 ls held off", {hs_gate, ls_gate}, 2'b00);
    // R6 hold cleared by high-side decision
    cmp_hi = 1'b1; cyc(12);
    check("R6 hs after hold", {hs_gate, ls_gate}, 2'b10);
    // R5 zero-current while low side off is ignored
    zc_det = 1'b1; cyc(1); zc_det = 1'b0; cyc(4);
    cmp_hi = 1'b0; cyc(12);
    check("R6 ls back on", {hs_gate, ls_gate}, 2'b01);
    check("R5 zc ignored while ls off", {hs_gate, ls_gate}, 2'b01);

    // R10 enable clears the zero-current hold
    zc_det = 1'b1; cyc(1); zc_det = 1'b0; cyc(12);
    check("R5 hold again", {hs_gate, ls_gate}, 2'b00);
    en = 1'b0; cyc(5);
    check("R10 disabled", {hs_gate, ls_gate}, 2'b00);
    en = 1'b1; cyc(14);
    check("R10 hold cleared", {hs_gate, ls_gate}, 2'b01);

    // R8 overvoltage overrides the zero-current hold
    zc_det = 1'b1; cyc(1); zc_det = 1'b0; cyc(12);
    fault = 3'b010; cyc(2); fault = 3'b000; cyc(12);
    check("R8 ov over hold", {hs_gate, ls_gate}, 2'b01);
    reenable();

    // R7 R8 R9 fault bus sweep, both comparator states, then release
    for (int f = 0; f < 8; f++) begin
      for (int c = 0; c < 2; c++) begin
        fault = 3'b000;
        cmp_hi = c[0];
        reenable();
        fault = f[2:0]; cyc(12);
        check(f[0] ? "R7 uv applied" : (f[2] ? "R9 ot applied" :
              (f[1] ? "R8 ov applied" : "R3 no fault")),
              {hs_gate, ls_gate}, fault_exp(f[2:0], c[0]));
        fault = 3'b000; cyc(12);
        check(f[2] ? "R9 ot held" : (f[1] ? "R8 ov held" : "R7 uv released"),
              {hs_gate, ls_gate}, fault_exp({f[2], f[1], 1'b0}, c[0]));
      end
    end

    // R9 undervoltage over remembered overvoltage
    fault = 3'b000; cmp_hi = 1'b1; reenable();
    fault = 3'b010; cyc(12); fault = 3'b001; cyc(12);
    check("R9 uv over ov", {hs_gate, ls_gate}, 2'b00);
    fault = 3'b000; cyc(12);
    check("R8 ov still held", {hs_gate, ls_gate}, 2'b01);
    reenable();
    check("R10 ov cleared", {hs_gate, ls_gate}, 2'b10);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule